// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block produces one output pulse for every N cycles of a fast clock, with N programmable as B·P + A. A dual-modulus prescaler divides either by P or by P+1. A swallow count A sets how many prescaler cycles in each output period run at P+1, and a main count B sets the total number of prescaler cycles in the period. P is chosen from four powers of two (8, 16, 32 or 64), so each choice gives a modulus pair P/P+1. The output pulse marks the end of a feedback period and feeds a phase comparator, which is outside this block. The whole circuit runs on the one fast clock.

The prescaler code, A and B are written together into a held latch by a one-cycle load strobe. The latched values are adopted only when an output period ends, so every period is computed from a single set of values. A setting with A greater than B, or with B equal to zero, cannot be realised by the counter pair. The block flags such a setting and goes quiet instead of producing a period of the wrong length. Once a valid setting is loaded, it restarts cleanly.

Top module: `dual_mod_divider`

## Requirements
- R1: With code c on `psel_i`, P = 8·2^c (00→8, 01→16, 10→32, 11→64). Rising edges of `div_o` are spaced exactly B·P + A clock cycles apart, where A is taken from `swal_i` and B from `main_i`.
- R2: `div_o` is high for exactly one clock cycle per period.
- R3: `load_i` high at a rising edge captures `psel_i`, `swal_i` and `main_i`. The captured values take effect at the next period end that follows that edge. A period already in progress keeps its length, and so does the period that starts at the same edge as the capture.
- R4: One cycle after a capture, `cfg_err_o` is 1 if the captured A > B or B = 0, and 0 otherwise.
- R5: If the held setting is invalid when a period ends, that period still ends with its pulse, and no further pulses follow. When a valid setting is captured at edge e, the next pulse is high after edge e+1+N.
- R6: While `rst_ni` is low, `div_o` and `cfg_err_o` are 0 and the held setting returns to code 00, A = 2, B = 4 (N = 34). The first pulse is high after the 34th rising edge following release.
- R7: The corner cases A = 0 (N = B·P) and A = B (N = B·(P+1)) give the exact period for every prescaler code.
- R8: While `load_i` is low, changes on `psel_i`, `swal_i` and `main_i` leave both the period and `cfg_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture strobe for the setting inputs |
| psel_i | input | 2 | Prescaler modulus code |
| swal_i | input | 6 | Swallow count A |
| main_i | input | 13 | Main count B |
| div_o | output | 1 | One-cycle pulse at the end of each period |
| cfg_err_o | output | 1 | Held setting is not realisable (A > B or B = 0) |

## Verification
The bench measures pulse spacing for a spread of settings that covers all four prescaler codes, A = 0, A = B, and the largest swallow count. A design that mis-decides the P+1 phase by one prescaler cycle is off by exactly one clock in these periods. The bench issues a load in the middle of a period and another on the very edge that ends a period. A design that applies values early or blends old and new values produces a period matching neither expected length. The bench loads invalid settings and checks that the period in flight completes and that the block then stays silent. It also checks that the restart after a valid load comes exactly N+1 cycles later, which catches designs that emit a stray pulse or lose the first period.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int unsigned DMD_SEL_W  = 2;
  localparam int unsigned DMD_A_W    = 6;
  localparam int unsigned DMD_B_W    = 13;
  localparam int unsigned DMD_BASE_L = 3;

  typedef enum logic [DMD_SEL_W-1:0] {
    PSEL_8_9   = 2'd0,
    PSEL_16_17 = 2'd1,
    PSEL_32_33 = 2'd2,
    PSEL_64_65 = 2'd3
  } psel_e;
endpackage

// File: rtl/dmd_cfg_latch.sv
module dmd_cfg_latch #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned A_W     = 6,
  parameter int unsigned B_W     = 13,
  parameter int unsigned DEF_SEL = 0,
  parameter int unsigned DEF_A   = 2,
  parameter int unsigned DEF_B   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [A_W-1:0]   a_o,
  output logic [B_W-1:0]   b_o,
  output logic             bad_o
);
  logic [SEL_W-1:0] sel_q;
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_W'(DEF_SEL);
      a_q   <= A_W'(DEF_A);
      b_q   <= B_W'(DEF_B);
    end else if (load_i) begin
      sel_q <= sel_i;
      a_q   <= a_i;
      b_q   <= b_i;
    end
  end

  // swallow count must fit inside the main count
  assign bad_o = ({{(B_W-A_W){1'b0}}, a_q} > b_q) || (b_q == '0);
  assign sel_o = sel_q;
  assign a_o   = a_q;
  assign b_o   = b_q;
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BASE_LOG2 = 3,
  parameter int unsigned DEF_SEL   = 0,
  parameter bit          DEF_PLUS  = 1'b1,
  localparam int unsigned NSEL     = 1 << SEL_W,
  localparam int unsigned PC_W     = BASE_LOG2 + NSEL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] start_sel_i,
  input  logic             start_plus_i,
  input  logic [SEL_W-1:0] cur_sel_i,
  input  logic             next_plus_i,
  output logic             tick_o
);
  localparam logic [PC_W-1:0] RST_PC =
    PC_W'((1 << (BASE_LOG2 + DEF_SEL)) - 1 + int'(DEF_PLUS));

  logic [PC_W-1:0] mod_m1 [NSEL];
  logic [PC_W-1:0] pc_q, pc_d;

  for (genvar g = 0; g < NSEL; g++) begin : g_mod
    assign mod_m1[g] = PC_W'((1 << (BASE_LOG2 + g)) - 1);
  end

  // count down from modulus-1 (+1 while swallowing); tick on zero
  always_comb begin
    pc_d = pc_q;
    if (start_i)
      pc_d = mod_m1[start_sel_i] + PC_W'(start_plus_i);
    else if (run_i)
      pc_d = (pc_q == '0) ? mod_m1[cur_sel_i] + PC_W'(next_plus_i)
                          : pc_q - PC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_PC;
    else         pc_q <= pc_d;
  end

  assign tick_o = run_i && (pc_q == '0);
endmodule

// File: rtl/dmd_swallow_main.sv
module dmd_swallow_main #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned DEF_A = 2,
  parameter int unsigned DEF_B = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [A_W-1:0] start_a_i,
  input  logic [B_W-1:0] start_b_i,
  input  logic           tick_i,
  output logic           next_plus_o,
  output logic           last_o
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= A_W'(DEF_A);
      b_q <= B_W'(DEF_B);
    end else if (start_i) begin
      a_q <= start_a_i;
      b_q <= start_b_i;
    end else if (tick_i) begin
      if (a_q != '0) a_q <= a_q - A_W'(1);
      b_q <= b_q - B_W'(1);
    end
  end

  // counts include the prescaler cycle in progress
  assign next_plus_o = a_q > A_W'(1);
  assign last_o      = b_q == B_W'(1);
endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
  parameter int unsigned SEL_W     = dmd_pkg::DMD_SEL_W,
  parameter int unsigned A_W       = dmd_pkg::DMD_A_W,
  parameter int unsigned B_W       = dmd_pkg::DMD_B_W,
  parameter int unsigned BASE_LOG2 = dmd_pkg::DMD_BASE_L,
  parameter int unsigned DEF_SEL   = 0,
  parameter int unsigned DEF_A     = 2,
  parameter int unsigned DEF_B     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] psel_i,
  input  logic [A_W-1:0]   swal_i,
  input  logic [B_W-1:0]   main_i,
  output logic             div_o,
  output logic             cfg_err_o
);
  localparam bit DEF_PLUS = (DEF_A != 0);

  logic [SEL_W-1:0] pend_sel;
  logic [A_W-1:0]   pend_a;
  logic [B_W-1:0]   pend_b;
  logic             pend_bad;
  logic             tick, last, next_plus;
  logic             boundary, start;
  logic             run_q, div_q;
  logic [SEL_W-1:0] act_sel_q;

  dmd_cfg_latch #(
    .SEL_W(SEL_W), .A_W(A_W), .B_W(B_W),
    .DEF_SEL(DEF_SEL), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk_i (clk_i),   .rst_ni(rst_ni),  .load_i(load_i),
    .sel_i (psel_i),  .a_i   (swal_i),  .b_i   (main_i),
    .sel_o (pend_sel), .a_o  (pend_a),  .b_o   (pend_b),
    .bad_o (pend_bad)
  );

  // a stalled engine retries every cycle
  assign boundary = run_q ? (tick && last) : 1'b1;
  assign start    = boundary && !pend_bad;

  dmd_prescaler #(
    .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2),
    .DEF_SEL(DEF_SEL), .DEF_PLUS(DEF_PLUS)
  ) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .start_i     (start),
    .start_sel_i (pend_sel),
    .start_plus_i(pend_a != '0),
    .cur_sel_i   (act_sel_q),
    .next_plus_i (next_plus),
    .tick_o      (tick)
  );

  dmd_swallow_main #(
    .A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_a_i  (pend_a),
    .start_b_i  (pend_b),
    .tick_i     (tick),
    .next_plus_o(next_plus),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b1;
      act_sel_q <= SEL_W'(DEF_SEL);
      div_q     <= 1'b0;
    end else begin
      if (boundary) run_q <= !pend_bad;
      if (start)    act_sel_q <= pend_sel;
      div_q <= tick && last;
    end
  end

  assign div_o     = div_q;
  assign cfg_err_o = pend_bad;
endmodule

// File: rtl/dual_mod_divider_chk.sv
module dual_mod_divider_chk #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 13,
  parameter int unsigned MIN_N = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           load_i,
  input logic [A_W-1:0] swal_i,
  input logic [B_W-1:0] main_i,
  input logic           div_o,
  input logic           cfg_err_o
);
  logic        bad_in;
  int unsigned gap_q;

  assign bad_in = ({{(B_W-A_W){1'b0}}, swal_i} > main_i) || (main_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= 0;
    else if (div_o)           gap_q <= 1;
    else if (gap_q < MIN_N)   gap_q <= gap_q + 1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);                                   // R2
  AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (gap_q >= MIN_N));                         // R1
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bad_in) |=> cfg_err_o);                   // R4
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !bad_in) |=> !cfg_err_o);                 // R4
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_err_o));                     // R8
endmodule

bind dual_mod_divider dual_mod_divider_chk #(
  .A_W(A_W), .B_W(B_W), .MIN_N(1 << BASE_LOG2)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .swal_i   (swal_i),
  .main_i   (main_i),
  .div_o    (div_o),
  .cfg_err_o(cfg_err_o)
);

// File: tb/dual_mod_divider_test.sv
module dual_mod_divider_test;
  import dmd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20000;
  localparam int NV         = 12;

  typedef struct packed {
    logic [1:0]  sel;
    logic [5:0]  a;
    logic [12:0] b;
    logic [19:0] n;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{PSEL_8_9,   6'd0,  13'd1,   20'd8},
    '{PSEL_8_9,   6'd1,  13'd1,   20'd9},
    '{PSEL_8_9,   6'd3,  13'd5,   20'd43},
    '{PSEL_16_17, 6'd0,  13'd3,   20'd48},
    '{PSEL_16_17, 6'd3,  13'd3,   20'd51},
    '{PSEL_32_33, 6'd7,  13'd9,   20'd295},
    '{PSEL_64_65, 6'd0,  13'd2,   20'd128},
    '{PSEL_64_65, 6'd2,  13'd2,   20'd130},
    '{PSEL_32_33, 6'd5,  13'd5,   20'd165},
    '{PSEL_8_9,   6'd63, 13'd63,  20'd567},
    '{PSEL_16_17, 6'd17, 13'd40,  20'd657},
    '{PSEL_64_65, 6'd63, 13'd100, 20'd6463}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        load = 1'b0;
  logic [1:0]  psel = '0;
  logic [5:0]  swal = '0;
  logic [12:0] mainv = '0;
  logic        div_o, cfg_err_o;
  int          n_chk = 0;
  int          n_fail = 0;

  dual_mod_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .psel_i(psel), .swal_i(swal), .main_i(mainv),
    .div_o(div_o), .cfg_err_o(cfg_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [1:0] s, input logic [5:0] a, input logic [12:0] b);
    psel = s; swal = a; mainv = b; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // cycles from the current negedge to the next sampled pulse
  task automatic to_pulse(output int n);
    n = 1;
    @(negedge clk);
    chk(div_o == 1'b0, "R2", int'(div_o), 0);
    while (!div_o && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (!div_o) chk(1'b0, "R1 timeout", n, LIMIT);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n, q, ex;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(div_o == 1'b0, "R6", int'(div_o), 0);
    chk(cfg_err_o == 1'b0, "R6", int'(cfg_err_o), 0);
    rst_n = 1'b1;
    to_pulse(n); chk(n == 34, "R6", n, 34);
    to_pulse(n); chk(n == 34, "R1", n, 34);

    // table walk: skip the period in flight, then measure the new one
    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i].sel, VECS[i].a, VECS[i].b);
      chk(cfg_err_o == 1'b0, "R4", int'(cfg_err_o), 0);
      to_pulse(n);
      to_pulse(n);
      ex = int'(VECS[i].n);
      if (VECS[i].a == 6'd0 || VECS[i].a == VECS[i].b[5:0] && VECS[i].b < 13'd64)
        chk(n == ex, "R7", n, ex);
      else
        chk(n == ex, "R1", n, ex);
    end

    load_cfg(PSEL_16_17, 6'd3, 13'd3);
    to_pulse(n);
    to_pulse(n); chk(n == 51, "R1", n, 51);

    // inputs move without a strobe
    psel = PSEL_64_65; swal = 6'd0; mainv = 13'd7;
    to_pulse(n); chk(n == 51, "R8", n, 51);
    chk(cfg_err_o == 1'b0, "R8", int'(cfg_err_o), 0);
    swal = 6'd40; mainv = 13'd2;
    to_pulse(n); chk(n == 51, "R8", n, 51);
    chk(cfg_err_o == 1'b0, "R8", int'(cfg_err_o), 0);

    // load in mid-period: current period keeps its length
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 5) begin psel = PSEL_8_9; swal = 6'd1; mainv = 13'd2; load = 1'b1; end
      if (n == 6) load = 1'b0;
    end while (!div_o && n < LIMIT);
    chk(n == 51, "R3", n, 51);
    to_pulse(n); chk(n == 17, "R3", n, 17);

    // load captured on the edge that ends a period
    repeat (15) @(negedge clk);
    @(negedge clk);
    psel = PSEL_16_17; swal = 6'd0; mainv = 13'd1; load = 1'b1;
    @(negedge clk);
    chk(div_o == 1'b1, "R3", int'(div_o), 1);
    load = 1'b0;
    to_pulse(n); chk(n == 17, "R3", n, 17);
    to_pulse(n); chk(n == 16, "R3", n, 16);

    // invalid settings
    load_cfg(PSEL_8_9, 6'd5, 13'd3);
    chk(cfg_err_o == 1'b1, "R4", int'(cfg_err_o), 1);
    to_pulse(n); chk(n == 15, "R5", n, 15);
    q = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (div_o) q++;
    end
    chk(q == 0, "R5", q, 0);
    load_cfg(PSEL_8_9, 6'd0, 13'd0);
    chk(cfg_err_o == 1'b1, "R4", int'(cfg_err_o), 1);
    load_cfg(PSEL_32_33, 6'd1, 13'd1);
    chk(cfg_err_o == 1'b0, "R4", int'(cfg_err_o), 0);
    to_pulse(n); chk(n == 34, "R5", n, 34);
    to_pulse(n); chk(n == 33, "R1", n, 33);

    // reset mid-run restores the default setting
    load_cfg(PSEL_8_9, 6'd9, 13'd2);
    chk(cfg_err_o == 1'b1, "R4", int'(cfg_err_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(div_o == 1'b0, "R6", int'(div_o), 0);
    chk(cfg_err_o == 1'b0, "R6", int'(cfg_err_o), 0);
    rst_n = 1'b1;
    to_pulse(n); chk(n == 34, "R6", n, 34);
    to_pulse(n); chk(n == 34, "R6", n, 34);

    summary();
    $finish;
  end
endmodule